// File: doc/BRIEF.md
# Parallel-Port Register Access Sequencer

This block sits on the host side of a standard parallel port. It reads or writes one register of a remote bridge that sits between the parallel port and a disk interface. It drives the eight data lines and the control lines, and it samples the status lines and the control read-back lines. For each request it plays a fixed sequence of port updates and samples. The sequence depends on the transfer mode and on the direction of the access. Before any of this, the register address is scrambled with a constant XOR key that also depends on the mode and the direction.

Three transfer modes are supported. Nibble mode rebuilds a read byte from two 4-bit status samples. Split mode rebuilds it from five status bits and three control read-back bits. Byte mode turns the data lines around and reads them directly. Every port update, and every sample, is held for a programmable number of clock cycles before the sequence moves on. This gives the remote side settling time. A requester presents the mode, the bank select, the index and the write value with a level request. It gets back a completion acknowledge, a read byte and an error flag.

Top module: `pport_reg_seq`

## Requirements
- R1: After synchronous reset: data output is 0x00, control output is 0x04, the data output enable is high, and acknowledge, error and read byte are all 0.
- R2: The remote address is {bank, index[6:0]}, so the control bank adds 0x80. It is XORed with a key: 0x19 for any write, 0x39 for a read in mode 0 (nibble), 0x31 for a read in mode 1 (split), and 0x29 for a read in mode 2 (byte).
- R3: A mode-0 read drives, in order: data=a, ctrl=0x01, ctrl=0x03, data=a. It then samples status as A, drives ctrl=0x01, samples status as B, and drives ctrl=0x04. The result is {B[7:4], A[7:4]}.
- R4: A mode-1 read drives, in order: data=a, ctrl=0x01, data=a&0x37, ctrl=0x03, ctrl=0x05, data=a|0xF0. It then samples status as A and control read-back as B, and drives ctrl=0x04. The result is {B[3:1], A[7:3]}.
- R5: A mode-2 read drives, in order: data=a, ctrl=0x01, ctrl=0x21, ctrl=0x23. It then samples the data input lines as the result and drives ctrl=0x04.
- R6: A write in modes 0 to 2 drives, in order: data=a, ctrl=0x01, data=value, ctrl=0x03, ctrl=0x04. It completes with read byte 0x00 and error 0.
- R7: Every update and every sample of a sequence occupies H+1 cycles, where H is the hold value latched when the request is accepted. From the cycle the request is raised, acknowledge is seen N*(H+1)+2 cycles later, where N is the number of updates and samples in the sequence. A change of the hold input during a transfer has no effect on that transfer.
- R8: The data output enable is the inverse of control bit 5. It is therefore low while the data lines are sampled in a mode-2 read.
- R9: Mode codes 3 to 7 complete without touching the port. Acknowledge comes one cycle after the request, with read byte 0xFF and error 1.
- R10: Acknowledge stays high while the request stays high, and falls one cycle after the request falls. A new request raised in the cycle after that is accepted and served normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Access request, held high until acknowledge |
| req_mode_i | input | 3 | Transfer mode code (0 nibble, 1 split, 2 byte) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_bank_i | input | 1 | 1 = control register bank |
| req_index_i | input | 7 | Register index |
| req_wdata_i | input | 8 | Write value |
| hold_cycles_i | input | HOLD_W | Extra hold cycles per step |
| ack_o | output | 1 | Completion acknowledge |
| rdata_o | output | 8 | Read result |
| err_o | output | 1 | Unsupported mode flag |
| pd_out_o | output | 8 | Parallel data lines out |
| pd_oe_o | output | 1 | Data line output enable |
| pd_in_i | input | 8 | Parallel data lines in |
| pc_out_o | output | 8 | Control register value driven |
| pc_in_i | input | 8 | Control lines read back |
| ps_in_i | input | 8 | Status lines in |

## Verification
Two things can meet in one cycle: the release of one transfer and the acceptance of the next. The acknowledge falls on the same edge that the sequencer returns to idle. A request raised right after that must start a clean sequence, with fresh latched fields and a cleared hold counter. The bench provokes this by holding the request past acknowledge for several cycles and then dropping it. It raises the next request one cycle later. The bench then judges both transfers on their full port traces, their latencies and their read bytes. A second collision, a hold input changed on the cycle after acceptance, is judged purely by latency.

// File: rtl/pport_seq_pkg.sv
// Package: shared types and constants for the parallel-port register sequencer.
// Assumes 8-bit port registers and a 7-bit index with a one-bit bank select.
package pport_seq_pkg;

    localparam int STEP_W   = 4;
    localparam int MAX_MODE = 2;

    localparam logic [7:0] KEY_NIB  = 8'h39;
    localparam logic [7:0] KEY_SPL  = 8'h31;
    localparam logic [7:0] KEY_BYTE = 8'h29;
    localparam logic [7:0] KEY_WR   = 8'h19;

    typedef enum logic [1:0] {S_IDLE, S_RUN, S_ACK} seq_state_e;

    typedef enum logic [2:0] {K_DATA, K_CTRL, K_SAMP_A, K_SAMP_B, K_END} step_kind_e;

    typedef enum logic [1:0] {DS_ADDR, DS_ADDR_LO, DS_ADDR_HI, DS_WDATA} data_src_e;

    typedef enum logic [1:0] {SS_STATUS, SS_CTRLIN, SS_DATAIN} samp_src_e;

    typedef struct packed {
        step_kind_e kind;
        data_src_e  dsrc;
        samp_src_e  ssrc;
        logic [7:0] ctrl;
    } step_t;

    // True for the mode codes this engine knows how to sequence.
    function automatic logic mode_ok(input logic [2:0] m);
        return m <= 3'(MAX_MODE);
    endfunction

    // Address scramble key for a given mode and direction.
    function automatic logic [7:0] addr_key(input logic [2:0] m, input logic wr);
        if (wr)          return KEY_WR;
        else if (m == 0) return KEY_NIB;
        else if (m == 1) return KEY_SPL;
        else             return KEY_BYTE;
    endfunction

endpackage

// File: rtl/pport_step_rom.sv
// Step table: maps (mode, direction, step number) to one port action.
// Assumes the caller only presents supported modes; anything else yields END.
module pport_step_rom
    import pport_seq_pkg::*;
(
    input  logic [2:0]        mode_i,
    input  logic              write_i,
    input  logic [STEP_W-1:0] idx_i,
    output step_t             step_o
);

    function automatic step_t mk(input step_kind_e k, input data_src_e d,
                                 input samp_src_e s, input logic [7:0] c);
        step_t t;
        t.kind = k;
        t.dsrc = d;
        t.ssrc = s;
        t.ctrl = c;
        return t;
    endfunction

    // Decode the step list for the current access.
    always_comb begin
        int unsigned k;
        k = int'(idx_i);
        step_o = mk(K_END, DS_ADDR, SS_STATUS, 8'h00);
        if (write_i) begin
            case (k)
                0: step_o = mk(K_DATA, DS_ADDR,  SS_STATUS, 8'h00);
                1: step_o = mk(K_CTRL, DS_ADDR,  SS_STATUS, 8'h01);
                2: step_o = mk(K_DATA, DS_WDATA, SS_STATUS, 8'h00);
                3: step_o = mk(K_CTRL, DS_ADDR,  SS_STATUS, 8'h03);
                4: step_o = mk(K_CTRL, DS_ADDR,  SS_STATUS, 8'h04);
                default: ;
            endcase
        end else if (mode_i == 3'd0) begin
            case (k)
                0: step_o = mk(K_DATA,   DS_ADDR, SS_STATUS, 8'h00);
                1: step_o = mk(K_CTRL,   DS_ADDR, SS_STATUS, 8'h01);
                2: step_o = mk(K_CTRL,   DS_ADDR, SS_STATUS, 8'h03);
                3: step_o = mk(K_DATA,   DS_ADDR, SS_STATUS, 8'h00);
                4: step_o = mk(K_SAMP_A, DS_ADDR, SS_STATUS, 8'h00);
                5: step_o = mk(K_CTRL,   DS_ADDR, SS_STATUS, 8'h01);
                6: step_o = mk(K_SAMP_B, DS_ADDR, SS_STATUS, 8'h00);
                7: step_o = mk(K_CTRL,   DS_ADDR, SS_STATUS, 8'h04);
                default: ;
            endcase
        end else if (mode_i == 3'd1) begin
            case (k)
                0: step_o = mk(K_DATA,   DS_ADDR,    SS_STATUS, 8'h00);
                1: step_o = mk(K_CTRL,   DS_ADDR,    SS_STATUS, 8'h01);
                2: step_o = mk(K_DATA,   DS_ADDR_LO, SS_STATUS, 8'h00);
                3: step_o = mk(K_CTRL,   DS_ADDR,    SS_STATUS, 8'h03);
                4: step_o = mk(K_CTRL,   DS_ADDR,    SS_STATUS, 8'h05);
                5: step_o = mk(K_DATA,   DS_ADDR_HI, SS_STATUS, 8'h00);
                6: step_o = mk(K_SAMP_A, DS_ADDR,    SS_STATUS, 8'h00);
                7: step_o = mk(K_SAMP_B, DS_ADDR,    SS_CTRLIN, 8'h00);
                8: step_o = mk(K_CTRL,   DS_ADDR,    SS_STATUS, 8'h04);
                default: ;
            endcase
        end else if (mode_i == 3'd2) begin
            case (k)
                0: step_o = mk(K_DATA,   DS_ADDR, SS_STATUS, 8'h00);
                1: step_o = mk(K_CTRL,   DS_ADDR, SS_STATUS, 8'h01);
                2: step_o = mk(K_CTRL,   DS_ADDR, SS_STATUS, 8'h21);
                3: step_o = mk(K_CTRL,   DS_ADDR, SS_STATUS, 8'h23);
                4: step_o = mk(K_SAMP_A, DS_ADDR, SS_DATAIN, 8'h00);
                5: step_o = mk(K_CTRL,   DS_ADDR, SS_STATUS, 8'h04);
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/pport_hold_timer.sv
// Hold timer: counts 0..limit repeatedly while running, flagging the first
// and last cycle of each step window. Assumes limit is stable while running.
module pport_hold_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             first_o,
    output logic             last_o
);

    logic [CNT_W-1:0] cnt_q;

    // Step window counter, cleared whenever the sequencer is not running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) cnt_q <= '0;
        else if (last_o)      cnt_q <= '0;
        else                  cnt_q <= cnt_q + 1'b1;
    end

    assign first_o = (cnt_q == '0);
    assign last_o  = (cnt_q == limit_i);

    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> cnt_q <= limit_i)
        else $error("hold counter ran past its limit");

endmodule

// File: rtl/pport_byte_join.sv
// Byte assembly: rebuilds the read byte from the two captured samples
// according to the transfer mode. Purely combinational.
module pport_byte_join (
    input  logic [2:0] mode_i,
    input  logic [7:0] samp_a_i,
    input  logic [7:0] samp_b_i,
    output logic [7:0] byte_o
);

    // Select the fragment layout for the mode.
    always_comb begin
        case (mode_i)
            3'd0:    byte_o = {samp_b_i[7:4], samp_a_i[7:4]};
            3'd1:    byte_o = {samp_b_i[3:1], samp_a_i[7:3]};
            default: byte_o = samp_a_i;
        endcase
    end

endmodule

// File: rtl/pport_reg_seq.sv
// Top: accepts a register access request, plays the mode's step list on the
// parallel port with a hold window per step, and returns the read byte.
// Assumes a four-phase request/acknowledge handshake from the requester.
module pport_reg_seq
    import pport_seq_pkg::*;
#(
    parameter int HOLD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [2:0]        req_mode_i,
    input  logic              req_write_i,
    input  logic              req_bank_i,
    input  logic [6:0]        req_index_i,
    input  logic [7:0]        req_wdata_i,
    input  logic [HOLD_W-1:0] hold_cycles_i,
    output logic              ack_o,
    output logic [7:0]        rdata_o,
    output logic              err_o,
    output logic [7:0]        pd_out_o,
    output logic              pd_oe_o,
    input  logic [7:0]        pd_in_i,
    output logic [7:0]        pc_out_o,
    input  logic [7:0]        pc_in_i,
    input  logic [7:0]        ps_in_i
);

    localparam logic [7:0] CTRL_REST = 8'h04;
    localparam int         DIR_BIT   = 5;

    seq_state_e        state_q;
    logic [2:0]        mode_q;
    logic              wr_q;
    logic [7:0]        addr_raw_q;
    logic [7:0]        wdata_q;
    logic [HOLD_W-1:0] hold_q;
    logic [STEP_W-1:0] idx_q;
    logic [7:0]        pd_q, pc_q;
    logic [7:0]        samp_a_q, samp_b_q;
    logic [7:0]        rdata_q;
    logic              err_q;

    step_t      step;
    logic       running, win_first, win_last, do_step;
    logic [7:0] addr_x, dval, sval, joined;

    pport_step_rom i_rom (
        .mode_i  (mode_q),
        .write_i (wr_q),
        .idx_i   (idx_q),
        .step_o  (step)
    );

    pport_hold_timer #(.CNT_W(HOLD_W)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (running),
        .limit_i (hold_q),
        .first_o (win_first),
        .last_o  (win_last)
    );

    pport_byte_join i_join (
        .mode_i   (mode_q),
        .samp_a_i (samp_a_q),
        .samp_b_i (samp_b_q),
        .byte_o   (joined)
    );

    assign running = (state_q == S_RUN);
    assign do_step = running && win_first;
    assign addr_x  = addr_raw_q ^ addr_key(mode_q, wr_q);

    // Value driven on the data lines by a data step.
    always_comb begin
        case (step.dsrc)
            DS_ADDR:    dval = addr_x;
            DS_ADDR_LO: dval = addr_x & 8'h37;
            DS_ADDR_HI: dval = addr_x | 8'hF0;
            default:    dval = wdata_q;
        endcase
    end

    // Input lines captured by a sample step.
    always_comb begin
        case (step.ssrc)
            SS_CTRLIN: sval = pc_in_i;
            SS_DATAIN: sval = pd_in_i;
            default:   sval = ps_in_i;
        endcase
    end

    // Request capture, step execution and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            mode_q     <= '0;
            wr_q       <= 1'b0;
            addr_raw_q <= '0;
            wdata_q    <= '0;
            hold_q     <= '0;
            idx_q      <= '0;
            pd_q       <= '0;
            pc_q       <= CTRL_REST;
            samp_a_q   <= '0;
            samp_b_q   <= '0;
            rdata_q    <= '0;
            err_q      <= 1'b0;
        end else begin
            case (state_q)
                S_IDLE: if (req_i) begin
                    mode_q     <= req_mode_i;
                    wr_q       <= req_write_i;
                    addr_raw_q <= {req_bank_i, req_index_i};
                    wdata_q    <= req_wdata_i;
                    hold_q     <= hold_cycles_i;
                    idx_q      <= '0;
                    if (mode_ok(req_mode_i)) begin
                        state_q <= S_RUN;
                    end else begin
                        state_q <= S_ACK;
                        rdata_q <= 8'hFF;
                        err_q   <= 1'b1;
                    end
                end
                S_RUN: begin
                    if (do_step) begin
                        case (step.kind)
                            K_DATA:   pd_q     <= dval;
                            K_CTRL:   pc_q     <= step.ctrl;
                            K_SAMP_A: samp_a_q <= sval;
                            K_SAMP_B: samp_b_q <= sval;
                            default: begin
                                state_q <= S_ACK;
                                rdata_q <= wr_q ? 8'h00 : joined;
                                err_q   <= 1'b0;
                            end
                        endcase
                    end
                    if (win_last) idx_q <= idx_q + 1'b1;
                end
                default: if (!req_i) state_q <= S_IDLE;
            endcase
        end
    end

    assign ack_o    = (state_q == S_ACK);
    assign rdata_o  = rdata_q;
    assign err_o    = err_q;
    assign pd_out_o = pd_q;
    assign pc_out_o = pc_q;
    assign pd_oe_o  = ~pc_q[DIR_BIT];

    p_port_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !do_step |=> $stable(pd_q) && $stable(pc_q))
        else $error("port changed outside a step start");

    p_din_dir_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (do_step && step.kind == K_SAMP_A && step.ssrc == SS_DATAIN) |-> pc_q[DIR_BIT])
        else $error("data lines sampled while still driven");

    p_err_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> rdata_q == 8'hFF)
        else $error("error completion without 0xFF");

    p_ack_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && req_i) |=> ack_o)
        else $error("acknowledge dropped while request high");

    p_ack_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_o) |-> $past(req_i))
        else $error("acknowledge without request");

endmodule

// File: tb/test_pport_reg_seq.sv
module test_pport_reg_seq;

    localparam int HOLD_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic              req_i = 1'b0;
    logic [2:0]        req_mode_i = '0;
    logic              req_write_i = 1'b0;
    logic              req_bank_i = 1'b0;
    logic [6:0]        req_index_i = '0;
    logic [7:0]        req_wdata_i = '0;
    logic [HOLD_W-1:0] hold_cycles_i = '0;
    logic              ack_o, err_o, pd_oe_o;
    logic [7:0]        rdata_o, pd_out_o, pc_out_o, pd_in_i, pc_in_i, ps_in_i;
    logic [7:0]        rval = 8'h00;

    // Remote bridge model: answers on status / control / data lines.
    assign ps_in_i = (pc_out_o == 8'h03) ? {rval[3:0], 4'hA} :
                     (pc_out_o == 8'h01) ? {rval[7:4], 4'h5} :
                     (pc_out_o == 8'h05) ? {rval[4:0], 3'b101} : 8'h00;
    assign pc_in_i = {4'hF, rval[7:5], 1'b1};
    assign pd_in_i = pd_oe_o ? pd_out_o : rval;

    pport_reg_seq #(.HOLD_W(HOLD_W)) i_pport_reg_seq (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .req_mode_i(req_mode_i),
        .req_write_i(req_write_i), .req_bank_i(req_bank_i), .req_index_i(req_index_i),
        .req_wdata_i(req_wdata_i), .hold_cycles_i(hold_cycles_i), .ack_o(ack_o),
        .rdata_o(rdata_o), .err_o(err_o), .pd_out_o(pd_out_o), .pd_oe_o(pd_oe_o),
        .pd_in_i(pd_in_i), .pc_out_o(pc_out_o), .pc_in_i(pc_in_i), .ps_in_i(ps_in_i)
    );

    int checks = 0, errs = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Port trace monitor and output-enable watch.
    logic [15:0] tr [16];
    int          tr_n = 0;
    logic [15:0] mon_prev = '0;
    bit          mon_on = 1'b0;
    int          oe_bad = 0, oe_low = 0;
    always @(negedge clk) begin
        if (rst_n && (pd_oe_o !== !pc_out_o[5])) oe_bad++;
        if (rst_n && !pd_oe_o) oe_low++;
        if (mon_on && {pd_out_o, pc_out_o} != mon_prev) begin
            if (tr_n < 16) tr[tr_n] = {pd_out_o, pc_out_o};
            tr_n++;
            mon_prev = {pd_out_o, pc_out_o};
        end
    end

    // Expected trace built from the requirement sequences.
    logic [15:0] ex [16];
    int          ex_n, ex_steps;
    logic [7:0]  ex_pd, ex_pc;
    logic [15:0] ex_last;

    task automatic upd(input bit is_data, input logic [7:0] v);
        if (is_data) ex_pd = v; else ex_pc = v;
        ex_steps++;
        if ({ex_pd, ex_pc} != ex_last) begin
            ex[ex_n] = {ex_pd, ex_pc};
            ex_n++;
            ex_last = {ex_pd, ex_pc};
        end
    endtask

    task automatic smp();
        ex_steps++;
    endtask

    task automatic build_exp(input logic [2:0] m, input logic w, input logic b,
                             input logic [6:0] ix, input logic [7:0] wd);
        logic [7:0] key, a;
        ex_n = 0; ex_steps = 0;
        ex_pd = pd_out_o; ex_pc = pc_out_o; ex_last = {ex_pd, ex_pc};
        key = w ? 8'h19 : (m == 0) ? 8'h39 : (m == 1) ? 8'h31 : 8'h29;
        a = {b, ix} ^ key;
        if (m > 2) return;
        if (w) begin
            upd(1, a); upd(0, 8'h01); upd(1, wd); upd(0, 8'h03); upd(0, 8'h04);
        end else if (m == 0) begin
            upd(1, a); upd(0, 8'h01); upd(0, 8'h03); upd(1, a); smp();
            upd(0, 8'h01); smp(); upd(0, 8'h04);
        end else if (m == 1) begin
            upd(1, a); upd(0, 8'h01); upd(1, a & 8'h37); upd(0, 8'h03);
            upd(0, 8'h05); upd(1, a | 8'hF0); smp(); smp(); upd(0, 8'h04);
        end else begin
            upd(1, a); upd(0, 8'h01); upd(0, 8'h21); upd(0, 8'h23); smp();
            upd(0, 8'h04);
        end
    endtask

    // One full handshake with trace, latency and result checks.
    task automatic do_txn(input logic [2:0] m, input logic w, input logic b,
                          input logic [6:0] ix, input logic [7:0] wd, input logic [7:0] rv,
                          input logic [3:0] h, input int extra, input bit alter_hold);
        int lat, exp_lat;
        bit ok;
        string ttag;
        @(negedge clk);
        build_exp(m, w, b, ix, wd);
        rval = rv; hold_cycles_i = h;
        req_mode_i = m; req_write_i = w; req_bank_i = b; req_index_i = ix;
        req_wdata_i = wd; req_i = 1'b1;
        tr_n = 0; mon_prev = {pd_out_o, pc_out_o}; mon_on = 1'b1;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
            if (alter_hold && lat == 1) hold_cycles_i = 4'd0;
        end while (!ack_o && lat < 2000);
        mon_on = 1'b0;
        ttag = (m > 2) ? "R9" : w ? "R2+R6" : (m == 0) ? "R2+R3" : (m == 1) ? "R2+R4" : "R2+R5";
        ok = (tr_n == ex_n);
        for (int i = 0; i < ex_n && i < 16; i++) if (ok && tr[i] != ex[i]) ok = 1'b0;
        check(ok, {ttag, " trace"}, (tr_n > 0 && tr_n <= 16) ? {16'(tr_n), tr[tr_n-1]} : 32'(tr_n),
              (ex_n > 0) ? {16'(ex_n), ex[ex_n-1]} : 32'(ex_n));
        exp_lat = (m > 2) ? 1 : ex_steps * (int'(h) + 1) + 2;
        check(lat == exp_lat, (m > 2) ? "R9 latency" : "R7 latency", lat, exp_lat);
        check(rdata_o == ((m > 2) ? 8'hFF : w ? 8'h00 : rv), {ttag, " rdata"},
              rdata_o, (m > 2) ? 8'hFF : w ? 8'h00 : rv);
        check(err_o == (m > 2), {ttag, " err"}, err_o, (m > 2));
        if (extra > 0) begin
            repeat (extra) @(negedge clk);
            check(ack_o == 1'b1, "R10 ack held", ack_o, 1);
        end
        req_i = 1'b0;
        @(negedge clk);
        check(ack_o == 1'b0, "R10 ack release", ack_o, 0);
    endtask

    // Stimulus table: mode, write, bank, index, wdata, remote value, hold.
    localparam logic [31:0] VEC [11] = '{
        {3'd0, 1'b0, 1'b0, 7'h12, 8'h00, 8'hC3, 4'd0},
        {3'd0, 1'b0, 1'b1, 7'h05, 8'h00, 8'h5A, 4'd2},
        {3'd1, 1'b0, 1'b0, 7'h07, 8'h00, 8'h9E, 4'd0},
        {3'd1, 1'b0, 1'b1, 7'h7F, 8'h00, 8'h61, 4'd1},
        {3'd2, 1'b0, 1'b0, 7'h03, 8'h00, 8'hF0, 4'd0},
        {3'd2, 1'b0, 1'b1, 7'h06, 8'h00, 8'h0F, 4'd3},
        {3'd0, 1'b1, 1'b0, 7'h02, 8'hA5, 8'h00, 4'd0},
        {3'd1, 1'b1, 1'b1, 7'h06, 8'h3C, 8'h00, 4'd1},
        {3'd2, 1'b1, 1'b0, 7'h7F, 8'h00, 8'h00, 4'd0},
        {3'd5, 1'b0, 1'b0, 7'h11, 8'h00, 8'h77, 4'd2},
        {3'd7, 1'b1, 1'b1, 7'h22, 8'h99, 8'h00, 4'd0}
    };

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state.
        check(pd_out_o == 8'h00, "R1 data out", pd_out_o, 8'h00);
        check(pc_out_o == 8'h04, "R1 ctrl out", pc_out_o, 8'h04);
        check(pd_oe_o == 1'b1 && ack_o == 1'b0 && err_o == 1'b0 && rdata_o == 8'h00,
              "R1 flags", {pd_oe_o, ack_o, err_o, rdata_o}, {1'b1, 1'b0, 1'b0, 8'h00});
        rst_n = 1'b1;
        @(negedge clk);
        for (int v = 0; v < 11; v++) begin
            do_txn(VEC[v][31:29], VEC[v][28], VEC[v][27], VEC[v][26:20], VEC[v][19:12],
                   VEC[v][11:4], VEC[v][3:0], 0, 1'b0);
        end
        // R7: hold input changed after acceptance is ignored.
        do_txn(3'd2, 1'b0, 1'b1, 7'h40, 8'h00, 8'hB7, 4'd2, 0, 1'b1);
        // R10: request held past acknowledge, then back-to-back with one idle cycle.
        do_txn(3'd0, 1'b0, 1'b0, 7'h33, 8'h00, 8'h4E, 4'd1, 3, 1'b0);
        do_txn(3'd1, 1'b1, 1'b0, 7'h01, 8'hE1, 8'h00, 4'd0, 0, 1'b0);
        do_txn(3'd2, 1'b0, 1'b0, 7'h01, 8'h00, 8'h2D, 4'd0, 0, 1'b0);
        // R8: enable always mirrors direction bit, and drops during byte reads.
        check(oe_bad == 0, "R8 enable vs direction", oe_bad, 0);
        check(oe_low > 0, "R8 enable low seen", oe_low, 1);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errs++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule